// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out, in hertz, the frequencies that a configurable clock tree would deliver on two derived clocks: the register-interface bus clock and the peripheral clock. It starts from a fixed 24,000,000 Hz oscillator. It reads the mux-select and divider fields of the tree, which arrive as plain input ports, and walks the tree one stage at a time. The stages are the PLL multiply, the fractional stage, the root muxes, and then the chain of bus and peripheral dividers.

Every division in the walk runs on one shared restoring divider that produces one quotient bit per cycle. A one-cycle start pulse copies the configuration into the block and begins the walk. When both results are ready, the block loads them into its output registers and raises a one-cycle done pulse. The outputs keep those values until the next done pulse. The block only computes numbers; it generates no real clocks.

Top module: `clktree_calc`

## Requirements
- R1: While reset is applied and after it is released, `busy` and `done` are 0 and `ipg_hz` and `per_hz` are 0.
- R2: The oscillator is 24,000,000 Hz. The system PLL is the oscillator times 22 when `pll_mul_sel` is 1 and times 20 when it is 0. The USB PLL is always the oscillator times 20.
- R3: Fractional output k (k = 0 or 2) is floor(system PLL × 18 / `frack`), using 64-bit arithmetic. A fraction field of 0 makes that output 0 Hz.
- R4: `pre_sel` picks the pre-peripheral source. The encodings are 0 = system PLL, 1 = fractional output 2, 2 = fractional output 0, and 3 = fractional output 2 halved (floor).
- R5: `alt_sel` picks the alternate source. The encodings are 0 = USB PLL, 1 = oscillator, 2 = bypass (0 Hz) and 3 = reserved (0 Hz). The alternate path equals floor(source / (1 + `alt_div`)). `root_sel` = 0 selects the pre-peripheral path as the root and `root_sel` = 1 selects the alternate path.
- R6: The AHB clock is floor(root / (1 + `ahb_div`)). The bus clock `ipg_hz` is floor(AHB / (1 + `ipg_div`)).
- R7: The peripheral source is `ipg_hz` when `per_sel` = 0 and the oscillator when `per_sel` = 1. `per_hz` equals floor(source / (1 + `per_div`)).
- R8: A `start` pulse while idle copies all configuration inputs on that edge and raises `busy` on the next cycle. Exactly one single-cycle `done` pulse follows, within 1000 cycles. `busy` drops in the same cycle that `done` rises.
- R9: A `start` pulse or a configuration change while `busy` is high has no effect on the results of the calculation in progress and produces no extra `done` pulse.
- R10: `ipg_hz` and `per_hz` change only in a cycle where `done` is 1. Otherwise they hold their last results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| pll_mul_sel | input | 1 | System PLL multiplier select (1: ×22, 0: ×20) |
| frac0 | input | 6 | Fraction field of fractional output 0 |
| frac2 | input | 6 | Fraction field of fractional output 2 |
| pre_sel | input | 2 | Pre-peripheral source select |
| alt_sel | input | 2 | Alternate source select |
| alt_div | input | 3 | Alternate path divider field (divide by field+1) |
| root_sel | input | 1 | Root select (0: pre-peripheral, 1: alternate) |
| ahb_div | input | 3 | AHB divider field |
| ipg_div | input | 2 | Bus clock divider field |
| per_sel | input | 1 | Peripheral source select (0: bus clock, 1: oscillator) |
| per_div | input | 6 | Peripheral divider field |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when new results are loaded |
| ipg_hz | output | 64 | Bus clock frequency in Hz |
| per_hz | output | 64 | Peripheral clock frequency in Hz |

## Verification
The assertions assume that `start` is a clean synchronous pulse and that reset is held from time zero until after the first clock edge. The divider-side assertion also assumes the top never hands the divider a zero divisor. The block guarantees that itself by turning a zero fraction field into a 0 Hz result without issuing a division, so the stimulus may use zero fraction fields freely. The bench changes inputs only on falling edges. It holds `start` for exactly one cycle and deliberately pulses it again, with different settings, while a calculation is running.

// File: rtl/clktree_pkg.sv
package clktree_pkg;
    parameter int unsigned OSC_HZ = 24_000_000;

    localparam int unsigned SYS_MUL_HI = 22;
    localparam int unsigned SYS_MUL_LO = 20;
    localparam int unsigned USB_MUL    = 20;
    localparam int unsigned FRAC_NUM   = 18;

    localparam int FRAC_W = 6;
    localparam int ALT_W  = 3;
    localparam int AHB_W  = 3;
    localparam int IPG_W  = 2;
    localparam int PER_W  = 6;
    // widest divisor: peripheral field plus one
    localparam int DEN_W  = PER_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_ALT, ST_AHB, ST_IPG, ST_PER
    } stage_e;

    typedef struct packed {
        logic              mul_sel;
        logic [FRAC_W-1:0] frac0;
        logic [FRAC_W-1:0] frac2;
        logic [1:0]        pre_sel;
        logic [1:0]        alt_sel;
        logic [ALT_W-1:0]  alt_div;
        logic              root_sel;
        logic [AHB_W-1:0]  ahb_div;
        logic [IPG_W-1:0]  ipg_div;
        logic              per_sel;
        logic [PER_W-1:0]  per_div;
    } cfg_t;
endpackage

// File: rtl/clktree_pll.sv
module clktree_pll
    import clktree_pkg::*;
#(
    parameter int FW = 64
) (
    input  logic          mul_sel,
    output logic [FW-1:0] sys_hz,
    output logic [FW-1:0] usb_hz
);
    localparam logic [FW-1:0] OSC_F = FW'(OSC_HZ);

    always_comb begin
        sys_hz = OSC_F * (mul_sel ? FW'(SYS_MUL_HI) : FW'(SYS_MUL_LO));
        usb_hz = OSC_F * FW'(USB_MUL);
    end
endmodule

// File: rtl/clktree_div.sv
module clktree_div #(
    parameter int NW = 64,
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          busy,
    output logic          done,
    output logic [NW-1:0] quo
);
    localparam int CW = $clog2(NW + 1);

    typedef struct packed {
        logic          run;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rem;
        logic [DW-1:0] den;
        logic [NW-1:0] quo;
    } dv_t;

    dv_t q, d;
    logic [DW:0]   sh;
    logic [NW-1:0] qq;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        sh     = '0;
        qq     = '0;
        if (q.run) begin
            sh = {q.rem, q.quo[NW-1]};
            qq = {q.quo[NW-2:0], 1'b0};
            if (sh >= {1'b0, q.den}) begin
                sh    = sh - {1'b0, q.den};
                qq[0] = 1'b1;
            end
            d.rem = sh[DW-1:0];
            d.quo = qq;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end else if (start) begin
            d.run = 1'b1;
            d.rem = '0;
            d.den = den;
            d.quo = num;
            d.cnt = CW'(NW);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.run;
    assign done = q.done;
    assign quo  = q.quo;

    // R3
    dv_den_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |-> (den != '0));
    // R8
    dv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/clktree_calc.sv
module clktree_calc
    import clktree_pkg::*;
#(
    parameter int FW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pll_mul_sel,
    input  logic [FRAC_W-1:0] frac0,
    input  logic [FRAC_W-1:0] frac2,
    input  logic [1:0]        pre_sel,
    input  logic [1:0]        alt_sel,
    input  logic [ALT_W-1:0]  alt_div,
    input  logic              root_sel,
    input  logic [AHB_W-1:0]  ahb_div,
    input  logic [IPG_W-1:0]  ipg_div,
    input  logic              per_sel,
    input  logic [PER_W-1:0]  per_div,
    output logic              busy,
    output logic              done,
    output logic [FW-1:0]     ipg_hz,
    output logic [FW-1:0]     per_hz
);
    localparam logic [FW-1:0] OSC_F = FW'(OSC_HZ);

    typedef struct packed {
        stage_e        st;
        logic          iss;
        cfg_t          cfg;
        logic [FW-1:0] acc;
        logic [FW-1:0] ipg;
        logic [FW-1:0] ipg_out;
        logic [FW-1:0] per_out;
        logic          done;
    } top_t;

    top_t q, d;
    cfg_t cfg_in;

    logic [FW-1:0]     sys_hz, usb_hz, frac_num, alt_src;
    logic [FRAC_W-1:0] frac_sel;
    logic              dv_start, dv_busy, dv_done;
    logic [FW-1:0]     dv_num, dv_quo;
    logic [DEN_W-1:0]  dv_den;

    clktree_pll #(.FW(FW)) u_pll (
        .mul_sel (q.cfg.mul_sel),
        .sys_hz  (sys_hz),
        .usb_hz  (usb_hz)
    );

    clktree_div #(.NW(FW), .DW(DEN_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dv_start),
        .num   (dv_num),
        .den   (dv_den),
        .busy  (dv_busy),
        .done  (dv_done),
        .quo   (dv_quo)
    );

    always_comb begin
        cfg_in = '{mul_sel: pll_mul_sel, frac0: frac0, frac2: frac2,
                   pre_sel: pre_sel, alt_sel: alt_sel, alt_div: alt_div,
                   root_sel: root_sel, ahb_div: ahb_div, ipg_div: ipg_div,
                   per_sel: per_sel, per_div: per_div};
    end

    always_comb begin
        frac_num = sys_hz * FW'(FRAC_NUM);
        frac_sel = (q.cfg.pre_sel == 2'd2) ? q.cfg.frac0 : q.cfg.frac2;
        case (q.cfg.alt_sel)
            2'd0:    alt_src = usb_hz;
            2'd1:    alt_src = OSC_F;
            default: alt_src = '0;
        endcase
    end

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        dv_start = 1'b0;
        dv_num   = '0;
        dv_den   = '0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.cfg = cfg_in;
                    d.iss = 1'b0;
                    d.st  = cfg_in.root_sel ? ST_ALT : ST_PRE;
                end
            end
            ST_PRE: begin
                if (!q.iss) begin
                    if (q.cfg.pre_sel == 2'd0) begin
                        d.acc = sys_hz;
                        d.st  = ST_AHB;
                    end else if (frac_sel == '0) begin
                        d.acc = '0;
                        d.st  = ST_AHB;
                    end else begin
                        dv_start = 1'b1;
                        dv_num   = frac_num;
                        dv_den   = DEN_W'(frac_sel);
                        d.iss    = 1'b1;
                    end
                end else if (dv_done) begin
                    d.acc = (q.cfg.pre_sel == 2'd3) ? (dv_quo >> 1) : dv_quo;
                    d.iss = 1'b0;
                    d.st  = ST_AHB;
                end
            end
            ST_ALT: begin
                if (!q.iss) begin
                    dv_start = 1'b1;
                    dv_num   = alt_src;
                    dv_den   = DEN_W'(q.cfg.alt_div) + 1'b1;
                    d.iss    = 1'b1;
                end else if (dv_done) begin
                    d.acc = dv_quo;
                    d.iss = 1'b0;
                    d.st  = ST_AHB;
                end
            end
            ST_AHB: begin
                if (!q.iss) begin
                    dv_start = 1'b1;
                    dv_num   = q.acc;
                    dv_den   = DEN_W'(q.cfg.ahb_div) + 1'b1;
                    d.iss    = 1'b1;
                end else if (dv_done) begin
                    d.acc = dv_quo;
                    d.iss = 1'b0;
                    d.st  = ST_IPG;
                end
            end
            ST_IPG: begin
                if (!q.iss) begin
                    dv_start = 1'b1;
                    dv_num   = q.acc;
                    dv_den   = DEN_W'(q.cfg.ipg_div) + 1'b1;
                    d.iss    = 1'b1;
                end else if (dv_done) begin
                    d.ipg = dv_quo;
                    d.iss = 1'b0;
                    d.st  = ST_PER;
                end
            end
            ST_PER: begin
                if (!q.iss) begin
                    dv_start = 1'b1;
                    dv_num   = q.cfg.per_sel ? OSC_F : q.ipg;
                    dv_den   = DEN_W'(q.cfg.per_div) + 1'b1;
                    d.iss    = 1'b1;
                end else if (dv_done) begin
                    d.ipg_out = q.ipg;
                    d.per_out = dv_quo;
                    d.done    = 1'b1;
                    d.iss     = 1'b0;
                    d.st      = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = (q.st != ST_IDLE);
    assign done   = q.done;
    assign ipg_hz = q.ipg_out;
    assign per_hz = q.per_out;

    // R8
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));
    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ipg_hz) && $stable(per_hz)));
    // R9
    div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dv_busy);
endmodule

// File: tb/clktree_calc_test.sv
module clktree_calc_test;
    import clktree_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    cfg_t c;
    logic busy, done;
    logic [63:0] ipg_hz, per_hz;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int n_done = 0;

    always #2 clk = ~clk;

    clktree_calc #(.FW(64)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pll_mul_sel(c.mul_sel), .frac0(c.frac0), .frac2(c.frac2),
        .pre_sel(c.pre_sel), .alt_sel(c.alt_sel), .alt_div(c.alt_div),
        .root_sel(c.root_sel), .ahb_div(c.ahb_div), .ipg_div(c.ipg_div),
        .per_sel(c.per_sel), .per_div(c.per_div),
        .busy(busy), .done(done), .ipg_hz(ipg_hz), .per_hz(per_hz)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && done) n_done++;
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic void ref_calc(cfg_t k, output logic [63:0] ipg,
                                     output logic [63:0] per);
        logic [63:0] osc, sys, usb, f0, f2, pre, src, alt, root, ahb;
        osc = 64'd24_000_000;
        sys = osc * (k.mul_sel ? 64'd22 : 64'd20);
        usb = osc * 64'd20;
        f0 = (k.frac0 == 0) ? 64'd0 : (sys * 64'd18) / 64'(k.frac0);
        f2 = (k.frac2 == 0) ? 64'd0 : (sys * 64'd18) / 64'(k.frac2);
        case (k.pre_sel)
            2'd0: pre = sys;
            2'd1: pre = f2;
            2'd2: pre = f0;
            default: pre = f2 / 64'd2;
        endcase
        case (k.alt_sel)
            2'd0: src = usb;
            2'd1: src = osc;
            default: src = 64'd0;
        endcase
        alt  = src / (64'(k.alt_div) + 64'd1);
        root = k.root_sel ? alt : pre;
        ahb  = root / (64'(k.ahb_div) + 64'd1);
        ipg  = ahb / (64'(k.ipg_div) + 64'd1);
        per  = (k.per_sel ? osc : ipg) / (64'(k.per_div) + 64'd1);
    endfunction

    function automatic cfg_t base_cfg();
        cfg_t k;
        k = '0;
        k.mul_sel = 1'b1;
        k.frac0 = 6'd27;
        k.frac2 = 6'd24;
        return k;
    endfunction

    // launch with k, wait for done, compare both outputs
    task automatic run_calc(string tag, cfg_t k);
        logic [63:0] ei, ep;
        int w;
        int d0;
        ref_calc(k, ei, ep);
        @(negedge clk);
        c = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        d0 = n_done;
        w = 0;
        while (!done && w < 1000) begin
            @(negedge clk);
            w++;
        end
        chk({tag, " R8 done within bound"}, 64'(done), 64'd1);
        chk({tag, " ipg_hz"}, ipg_hz, ei);
        chk({tag, " per_hz"}, per_hz, ep);
        @(negedge clk);
        chk({tag, " R8 single done pulse"}, 64'(n_done - d0), 64'd1);
        chk({tag, " R8 busy low after"}, 64'(busy), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 busy", 64'(busy), 0);
        chk("R1 done", 64'(done), 0);
        chk("R1 ipg_hz", ipg_hz, 0);
        chk("R1 per_hz", per_hz, 0);
    endtask

    task automatic t_launch();
        cfg_t k;
        k = base_cfg();
        @(negedge clk);
        c = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", 64'(busy), 1);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_pll();
        cfg_t k;
        k = base_cfg();
        run_calc("R2 sys x22", k);
        k.mul_sel = 1'b0;
        run_calc("R2 sys x20", k);
        k.root_sel = 1'b1;
        run_calc("R2 usb x20", k);
    endtask

    task automatic t_frac();
        cfg_t k;
        k = base_cfg();
        k.pre_sel = 2'd1;
        run_calc("R3 frac2=24", k);
        k.pre_sel = 2'd2;
        k.mul_sel = 1'b0;
        run_calc("R3 frac0=27 x20", k);
        k.frac0 = 6'd1;
        k.mul_sel = 1'b1;
        run_calc("R3 frac0=1 max", k);
        k.frac0 = 6'd0;
        run_calc("R3 frac0=0 zero", k);
        k.pre_sel = 2'd1;
        k.frac2 = 6'd0;
        run_calc("R3 frac2=0 zero", k);
    endtask

    task automatic t_pre();
        cfg_t k;
        k = base_cfg();
        k.pre_sel = 2'd3;
        run_calc("R4 pre3 halved", k);
        k.frac2 = 6'd35;
        run_calc("R4 pre3 frac35 floor", k);
        k.pre_sel = 2'd2;
        k.frac0 = 6'd63;
        run_calc("R4 pre2 frac63", k);
    endtask

    task automatic t_alt();
        cfg_t k;
        k = base_cfg();
        k.root_sel = 1'b1;
        k.alt_sel = 2'd0;
        k.alt_div = 3'd3;
        run_calc("R5 alt usb /4", k);
        k.alt_sel = 2'd1;
        k.alt_div = 3'd0;
        run_calc("R5 alt osc", k);
        k.alt_sel = 2'd2;
        run_calc("R5 alt bypass 0", k);
        k.alt_sel = 2'd3;
        k.alt_div = 3'd7;
        run_calc("R5 alt reserved 0", k);
    endtask

    task automatic t_bus();
        cfg_t k;
        k = base_cfg();
        k.ahb_div = 3'd6;
        k.ipg_div = 2'd3;
        run_calc("R6 ahb/7 ipg/4", k);
        k.ahb_div = 3'd3;
        k.ipg_div = 2'd1;
        run_calc("R6 ahb/4 ipg/2", k);
    endtask

    task automatic t_per();
        cfg_t k;
        k = base_cfg();
        k.per_sel = 1'b1;
        k.per_div = 6'd63;
        run_calc("R7 per osc /64", k);
        k.per_sel = 1'b0;
        k.per_div = 6'd5;
        k.ahb_div = 3'd2;
        run_calc("R7 per ipg /6", k);
    endtask

    task automatic t_busy_start();
        cfg_t a, b;
        logic [63:0] ei, ep;
        int d0;
        a = base_cfg();
        a.ahb_div = 3'd1;
        a.per_div = 6'd2;
        b = a;
        b.root_sel = 1'b1;
        b.alt_sel = 2'd1;
        b.per_sel = 1'b1;
        ref_calc(a, ei, ep);
        d0 = n_done;
        @(negedge clk);
        c = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        c = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk("R9 ipg unaffected", ipg_hz, ei);
        chk("R9 per unaffected", per_hz, ep);
        repeat (600) @(negedge clk);
        chk("R9 no extra done", 64'(n_done - d0), 64'd1);
    endtask

    task automatic t_hold();
        logic [63:0] hi, hp;
        int d0;
        hi = ipg_hz;
        hp = per_hz;
        d0 = n_done;
        c.per_div = 6'd9;
        c.mul_sel = ~c.mul_sel;
        repeat (50) @(negedge clk);
        chk("R10 ipg held", ipg_hz, hi);
        chk("R10 per held", per_hz, hp);
        chk("R10 no done", 64'(n_done - d0), 64'd0);
    endtask

    initial begin
        c = base_cfg();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_launch();
        t_pll();
        t_frac();
        t_pre();
        t_alt();
        t_bus();
        t_per();
        t_busy_start();
        t_hold();
        summary();
        $finish;
    end
endmodule